// File: doc/BRIEF.md
# Parallel Turbo-Decoder Bank Contention Checker

This block models how several parallel MAP engines reach their symbol memory during the interleaved half-iteration of a turbo decoder. A block of N symbols is cut into M equal contiguous slices, with M set to 2 or 4 by a parameter, and each slice sits in its own memory bank. On cycle t, engine k handles natural position j = k·S + t, where S = N/M. The block turns j into an interleaved address with the four-phase permutation rule. That rule adds a phase-dependent offset to (P0·j + 1) mod N, using 0, N/2 + P1, P2 and N/2 + P3 for j mod 4 = 0, 1, 2, 3. Each address is split into a bank number and a local offset. The block flags every cycle in which two or more engines land in the same bank, and the offsets do not matter for that flag.

One start pulse runs a whole pass. When the pass ends, the block reports whether every cycle was free of conflicts and how many cycles collided. The same pulse also starts a separate arithmetic checker. It tests whether the parameter set meets the algebraic conditions that guarantee two-engine conflict freedom for lengths divisible by 4 but not by 8. The gcd in that test is found by repeated subtraction over several cycles.

Top module: `ctc_bank_chk`

## Requirements
- R1: After reset, busy, done, cfg_err, pass, cyc_valid, cyc_collide, prm_done and prm_ok are 0 and coll_count is 0.
- R2: A start is rejected when n_len is not a multiple of 4, is below 8, or when any of p0..p3 is not below n_len. On rejection, done pulses in the following cycle with cfg_err=1, pass=0 and coll_count=0, and cyc_valid never rises.
- R3: During the pass, eng_addr field k (bits [k·NW +: NW]) on cycle t equals the four-phase permutation of j = k·S + t, where S = n_len/M.
- R4: eng_bank field k (bits [k·BW +: BW], BW = log2 M) equals floor(addr/S), and eng_ofs field k equals addr mod S.
- R5: cyc_collide is 1 on a valid cycle exactly when at least two engines report the same bank.
- R6: cyc_valid is high for exactly S consecutive cycles per accepted start.
- R7: done is a one-cycle pulse in the cycle right after the last valid cycle. coll_count then equals the number of colliding cycles, and pass = (coll_count == 0). These results, and cfg_err, hold until the next accepted start.
- R8: A start pulse while busy is high is ignored and does not disturb the pass in progress.
- R9: prm_ok is 1 exactly when p0 is odd, gcd(p0, n_len) = 1, p1 = p3, p1 is even and p2 = 0.
- R10: prm_done is a one-cycle pulse when the gcd evaluation finishes, and prm_ok holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass and a parameter check |
| n_len | input | NW | Interleaver length N |
| p0 | input | NW | Multiplier parameter |
| p1 | input | NW | Offset for phase 1 |
| p2 | input | NW | Offset for phase 2 |
| p3 | input | NW | Offset for phase 3 |
| busy | output | 1 | A pass or a parameter check is running |
| cyc_valid | output | 1 | Engine outputs are valid this cycle |
| cyc_collide | output | 1 | Two or more engines hit one bank |
| eng_addr | output | M·NW | Interleaved address per engine |
| eng_bank | output | M·BW | Bank number per engine |
| eng_ofs | output | M·NW | Offset within the bank per engine |
| done | output | 1 | Pass results are valid (pulse) |
| cfg_err | output | 1 | Last start was rejected |
| pass | output | 1 | Last pass had no collision |
| coll_count | output | NW | Colliding cycles in the last pass |
| prm_done | output | 1 | Parameter check finished (pulse) |
| prm_ok | output | 1 | Parameters meet the conflict-free conditions |

## Verification
The hardest case to reach from the ports is a collision that appears only on some phases of the four-phase rule, and only between engines whose start positions sit at different residues mod 4. Such a collision hides inside a pass that is otherwise clean. To expose it, the stimulus sweeps every residue of p0 for a 24-symbol block and crosses it with even, odd, equal and unequal phase offsets. Two-engine and four-engine instances run side by side on the same stimulus. Every engine's address, bank and offset is compared on every valid cycle, and one run fires a second start partway through the pass.

// File: rtl/ctc_bank_chk_pkg.sv
package ctc_bank_chk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_LOAD = 2'd2,
    ST_RUN  = 2'd3
  } pass_st_e;
endpackage

// File: rtl/ctc_prm_chk.sv
module ctc_prm_chk #(
  parameter int NW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] n_len,
  input  logic [NW-1:0] p0,
  input  logic [NW-1:0] p1,
  input  logic [NW-1:0] p2,
  input  logic [NW-1:0] p3,
  output logic          busy,
  output logic          done,
  output logic          ok
);
  logic          run_q, run_d;
  logic [NW-1:0] a_q, a_d, b_q, b_d;
  logic          cond_q, cond_d;
  logic          done_q, done_d;
  logic          ok_q, ok_d;
  logic [NW-1:0] gcd_w;
  logic          fin_w;

  assign fin_w = (a_q == '0) || (b_q == '0) || (a_q == b_q);
  assign gcd_w = (a_q == '0) ? b_q : a_q;

  always_comb begin
    run_d  = run_q;
    a_d    = a_q;
    b_d    = b_q;
    cond_d = cond_q;
    done_d = 1'b0;
    ok_d   = ok_q;
    if (go && !run_q) begin
      run_d  = 1'b1;
      a_d    = p0;
      b_d    = n_len;
      cond_d = p0[0] && (p1 == p3) && !p1[0] && (p2 == '0);
      ok_d   = 1'b0;
    end else if (run_q) begin
      if (fin_w) begin
        run_d  = 1'b0;
        done_d = 1'b1;
        ok_d   = cond_q && (gcd_w == NW'(1));
      end else if (a_q > b_q) begin
        a_d = a_q - b_q;
      end else begin
        b_d = b_q - a_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      cond_q <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      run_q  <= run_d;
      a_q    <= a_d;
      b_q    <= b_d;
      cond_q <= cond_d;
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  assign busy = run_q;
  assign done = done_q;
  assign ok   = ok_q;

  // R10
  gcd_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !fin_w) |=> ({1'b0, a_q} + {1'b0, b_q}) < $past({1'b0, a_q} + {1'b0, b_q}));

  // R10
  prm_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/ctc_eng_lane.sv
module ctc_eng_lane #(
  parameter int NW = 12,
  parameter int M  = 2,
  parameter int BW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          vld,
  input  logic [NW-1:0] base,
  input  logic [1:0]    jlo_init,
  input  logic [NW-1:0] n_len,
  input  logic [NW-1:0] seg,
  input  logic [NW-1:0] p0,
  input  logic [NW-1:0] p1,
  input  logic [NW-1:0] p2,
  input  logic [NW-1:0] p3,
  output logic [NW-1:0] addr,
  output logic [BW-1:0] bank,
  output logic [NW-1:0] ofs
);
  function automatic logic [NW-1:0] madd(input logic [NW-1:0] x, input logic [NW-1:0] y,
                                         input logic [NW-1:0] n);
    logic [NW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[NW-1:0];
  endfunction

  logic [NW-1:0] a_q, a_d;
  logic [1:0]    jlo_q, jlo_d;
  logic [NW-1:0] half_w, phase_w;
  logic [NW:0]   thr;
  logic [NW-1:0] lo;

  always_comb begin
    a_d   = a_q;
    jlo_d = jlo_q;
    if (load) begin
      a_d   = base;
      jlo_d = jlo_init;
    end else if (step) begin
      a_d   = madd(a_q, p0, n_len);
      jlo_d = jlo_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      jlo_q <= '0;
    end else begin
      a_q   <= a_d;
      jlo_q <= jlo_d;
    end
  end

  assign half_w = n_len >> 1;

  always_comb begin
    case (jlo_q)
      2'd1:    phase_w = madd(half_w, p1, n_len);
      2'd2:    phase_w = p2;
      2'd3:    phase_w = madd(half_w, p3, n_len);
      default: phase_w = '0;
    endcase
    addr = madd(madd(a_q, NW'(1), n_len), phase_w, n_len);
  end

  always_comb begin
    bank = '0;
    lo   = '0;
    thr  = {1'b0, seg};
    for (int k = 1; k < M; k++) begin
      if ({1'b0, addr} >= thr) begin
        bank = BW'(k);
        lo   = thr[NW-1:0];
      end
      thr = thr + {1'b0, seg};
    end
    ofs = addr - lo;
  end

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> addr < n_len);

  // R4
  bank_ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ofs < seg);
endmodule

// File: rtl/ctc_bank_chk.sv
module ctc_bank_chk
  import ctc_bank_chk_pkg::*;
#(
  parameter int NW      = 12,
  parameter int NUM_ENG = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NW-1:0]         n_len,
  input  logic [NW-1:0]         p0,
  input  logic [NW-1:0]         p1,
  input  logic [NW-1:0]         p2,
  input  logic [NW-1:0]         p3,
  output logic                  busy,
  output logic                  cyc_valid,
  output logic                  cyc_collide,
  output logic [NUM_ENG*NW-1:0] eng_addr,
  output logic [NUM_ENG*((NUM_ENG > 2) ? $clog2(NUM_ENG) : 1)-1:0] eng_bank,
  output logic [NUM_ENG*NW-1:0] eng_ofs,
  output logic                  done,
  output logic                  cfg_err,
  output logic                  pass,
  output logic [NW-1:0]         coll_count,
  output logic                  prm_done,
  output logic                  prm_ok
);
  localparam int LM = $clog2(NUM_ENG);
  localparam int BW = (NUM_ENG > 2) ? LM : 1;

  function automatic logic [NW-1:0] madd(input logic [NW-1:0] x, input logic [NW-1:0] y,
                                         input logic [NW-1:0] n);
    logic [NW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[NW-1:0];
  endfunction

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  pass_st_e      st_q, st_d;
  logic [NW-1:0] cnt_q, cnt_d, acc_q, acc_d;
  logic [NW-1:0] n_q, n_d, p0_q, p0_d, p1_q, p1_d, p2_q, p2_d, p3_q, p3_d;
  logic          done_q, done_d, err_q, err_d, pass_q, pass_d;
  logic [NW-1:0] ccnt_q, ccnt_d;
  logic [NW-1:0] s_q;
  logic          go, bad_cfg, prm_busy, last_w;
  logic          ld_w, step_w, vld_w, coll_w;

  logic [NW-1:0] base_w [NUM_ENG];
  logic [1:0]    jl_w   [NUM_ENG];
  logic [NW-1:0] addr_w [NUM_ENG];
  logic [BW-1:0] bank_w [NUM_ENG];
  logic [NW-1:0] ofs_w  [NUM_ENG];

  assign s_q     = n_q >> LM;
  assign busy    = (st_q != ST_IDLE) || prm_busy;
  assign go      = start && !busy;
  assign bad_cfg = (n_len[1:0] != 2'b00) || (n_len < NW'(8)) || (p0 >= n_len) ||
                   (p1 >= n_len) || (p2 >= n_len) || (p3 >= n_len);
  assign last_w  = (cnt_q == s_q - NW'(1));
  assign ld_w    = (st_q == ST_LOAD);
  assign vld_w   = (st_q == ST_RUN);
  assign step_w  = vld_w;

  // start point of each engine: k * (S * P0 mod N), and j mod 4 = (k * S) mod 4
  always_comb begin
    logic [NW-1:0] rb, rj;
    rb = '0;
    rj = '0;
    for (int k = 0; k < NUM_ENG; k++) begin
      base_w[k] = rb;
      jl_w[k]   = rj[1:0];
      rb        = madd(rb, acc_q, n_q);
      rj        = rj + s_q;
    end
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    n_d    = n_q;
    p0_d   = p0_q;
    p1_d   = p1_q;
    p2_d   = p2_q;
    p3_d   = p3_q;
    done_d = 1'b0;
    err_d  = err_q;
    pass_d = pass_q;
    ccnt_d = ccnt_q;
    case (st_q)
      ST_IDLE: begin
        if (go) begin
          ccnt_d = '0;
          pass_d = 1'b0;
          err_d  = bad_cfg;
          if (bad_cfg) begin
            done_d = 1'b1;
          end else begin
            st_d  = ST_PRE;
            cnt_d = '0;
            acc_d = '0;
            n_d   = n_len;
            p0_d  = p0;
            p1_d  = p1;
            p2_d  = p2;
            p3_d  = p3;
          end
        end
      end
      ST_PRE: begin
        acc_d = madd(acc_q, p0_q, n_q);
        cnt_d = cnt_q + NW'(1);
        if (last_w) begin
          st_d  = ST_LOAD;
          cnt_d = '0;
        end
      end
      ST_LOAD: st_d = ST_RUN;
      ST_RUN: begin
        if (coll_w) ccnt_d = ccnt_q + NW'(1);
        cnt_d = cnt_q + NW'(1);
        if (last_w) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          pass_d = (ccnt_d == '0);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      acc_q  <= '0;
      n_q    <= '0;
      p0_q   <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
      p3_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      pass_q <= 1'b0;
      ccnt_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      n_q    <= n_d;
      p0_q   <= p0_d;
      p1_q   <= p1_d;
      p2_q   <= p2_d;
      p3_q   <= p3_d;
      done_q <= done_d;
      err_q  <= err_d;
      pass_q <= pass_d;
      ccnt_q <= ccnt_d;
    end
  end

  for (genvar k = 0; k < NUM_ENG; k++) begin : g_lane
    ctc_eng_lane #(.NW(NW), .M(NUM_ENG), .BW(BW)) lane_i (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .load     (ld_w),
      .step     (step_w),
      .vld      (vld_w),
      .base     (base_w[k]),
      .jlo_init (jl_w[k]),
      .n_len    (n_q),
      .seg      (s_q),
      .p0       (p0_q),
      .p1       (p1_q),
      .p2       (p2_q),
      .p3       (p3_q),
      .addr     (addr_w[k]),
      .bank     (bank_w[k]),
      .ofs      (ofs_w[k])
    );
    assign eng_addr[k*NW +: NW] = addr_w[k];
    assign eng_bank[k*BW +: BW] = bank_w[k];
    assign eng_ofs[k*NW +: NW]  = ofs_w[k];
  end

  // pairwise bank comparison
  always_comb begin
    coll_w = 1'b0;
    for (int a = 0; a < NUM_ENG; a++)
      for (int b = a + 1; b < NUM_ENG; b++)
        if (bank_w[a] == bank_w[b]) coll_w = vld_w;
  end

  ctc_prm_chk #(.NW(NW)) prm_i (
    .clk   (clk),
    .rst_n (rst_s_n),
    .go    (go),
    .n_len (n_len),
    .p0    (p0),
    .p1    (p1),
    .p2    (p2),
    .p3    (p3),
    .busy  (prm_busy),
    .done  (prm_done),
    .ok    (prm_ok)
  );

  assign cyc_valid   = vld_w;
  assign cyc_collide = coll_w;
  assign done        = done_q;
  assign cfg_err     = err_q;
  assign pass        = pass_q;
  assign coll_count  = ccnt_q;

  logic [NUM_ENG-1:0] bank_hit;
  always_comb begin
    bank_hit = '0;
    for (int k = 0; k < NUM_ENG; k++) bank_hit[bank_w[k]] = 1'b1;
  end

  // R5
  distinct_banks_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cyc_valid && !cyc_collide) |-> $countones(bank_hit) == NUM_ENG);

  // R5
  shared_bank_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cyc_collide |-> (cyc_valid && $countones(bank_hit) < NUM_ENG));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_IDLE && !go) |=> ($stable(coll_count) && $stable(pass) && $stable(cfg_err)));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cyc_valid |-> coll_count <= cnt_q);
endmodule

// File: tb/ctc_bank_chk_tb_top.sv
module ctc_bank_chk_tb_top;
  localparam int NW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [NW-1:0] n_len = '0, p0 = '0, p1 = '0, p2 = '0, p3 = '0;

  logic          busy2, vld2, col2, done2, err2, pass2, pd2, pok2;
  logic [2*NW-1:0] addr2, ofs2;
  logic [1:0]    bank2;
  logic [NW-1:0] cnt2;
  logic          busy4, vld4, col4, done4, err4, pass4, pd4, pok4;
  logic [4*NW-1:0] addr4, ofs4;
  logic [7:0]    bank4;
  logic [NW-1:0] cnt4;

  ctc_bank_chk #(.NW(NW), .NUM_ENG(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len), .p0(p0), .p1(p1),
    .p2(p2), .p3(p3), .busy(busy2), .cyc_valid(vld2), .cyc_collide(col2),
    .eng_addr(addr2), .eng_bank(bank2), .eng_ofs(ofs2), .done(done2),
    .cfg_err(err2), .pass(pass2), .coll_count(cnt2), .prm_done(pd2), .prm_ok(pok2));

  ctc_bank_chk #(.NW(NW), .NUM_ENG(4)) dut4_i (
    .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len), .p0(p0), .p1(p1),
    .p2(p2), .p3(p3), .busy(busy4), .cyc_valid(vld4), .cyc_collide(col4),
    .eng_addr(addr4), .eng_bank(bank4), .eng_ofs(ofs4), .done(done4),
    .cfg_err(err4), .pass(pass4), .coll_count(cnt4), .prm_done(pd4), .prm_ok(pok4));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int m_addr(int n, int a0, int a1, int a2, int a3, int j);
    int b;
    b = (a0 * j + 1) % n;
    case (j % 4)
      1: b = (b + n / 2 + a1) % n;
      2: b = (b + a2) % n;
      3: b = (b + n / 2 + a3) % n;
      default: ;
    endcase
    return b;
  endfunction

  function automatic int m_gcd(int a, int b);
    while (b != 0) begin
      int r;
      r = a % b;
      a = b;
      b = r;
    end
    return a;
  endfunction

  // per-cycle check of one instance on valid cycle t
  task automatic lane_chk(input int m, input int n, input int a0, input int a1,
                          input int a2, input int a3, input int t,
                          input logic [4*NW-1:0] av, input logic [7:0] bv,
                          input logic [4*NW-1:0] ov, input logic col);
    int s, bw, ea, eb[4], ab, ao, aa;
    bit ecol;
    s  = n / m;
    bw = (m == 2) ? 1 : 2;
    for (int k = 0; k < m; k++) begin
      ea    = m_addr(n, a0, a1, a2, a3, k * s + t);
      eb[k] = ea / s;
      aa    = int'(av[k*NW +: NW]);
      ab    = int'((bv >> (k * bw)) & ((1 << bw) - 1));
      ao    = int'(ov[k*NW +: NW]);
      chk(aa == ea, "R3", $sformatf("m=%0d n=%0d t=%0d eng%0d addr", m, n, t, k), aa, ea);
      chk(ab == eb[k] && ao == ea % s, "R4",
          $sformatf("m=%0d n=%0d t=%0d eng%0d bank*1000+ofs", m, n, t, k),
          ab * 1000 + ao, eb[k] * 1000 + ea % s);
    end
    ecol = 1'b0;
    for (int a = 0; a < m; a++)
      for (int b = a + 1; b < m; b++)
        if (eb[a] == eb[b]) ecol = 1'b1;
    chk(col == ecol, "R5", $sformatf("m=%0d n=%0d t=%0d collide", m, n, t), int'(col), int'(ecol));
  endtask

  function automatic int m_coll(int m, int n, int a0, int a1, int a2, int a3);
    int s, c;
    s = n / m;
    c = 0;
    for (int t = 0; t < s; t++) begin
      bit hit;
      hit = 1'b0;
      for (int a = 0; a < m; a++)
        for (int b = a + 1; b < m; b++)
          if (m_addr(n, a0, a1, a2, a3, a * s + t) / s ==
              m_addr(n, a0, a1, a2, a3, b * s + t) / s) hit = 1'b1;
      if (hit) c++;
    end
    return c;
  endfunction

  task automatic run_one(input int n, input int a0, input int a1, input int a2,
                         input int a3, input bit glitch);
    bit bad, eok, s2, s4, sp2, sp4, pv2, pv4;
    int t2, t4, e2, e4, it, f0;
    f0  = n_fail;
    bad = (n % 4 != 0) || (n < 8) || (a0 >= n) || (a1 >= n) || (a2 >= n) || (a3 >= n);
    eok = (a0 % 2 == 1) && (m_gcd(a0, n) == 1) && (a1 == a3) && (a1 % 2 == 0) && (a2 == 0);
    e2  = bad ? 0 : m_coll(2, n, a0, a1, a2, a3);
    e4  = bad ? 0 : m_coll(4, n, a0, a1, a2, a3);
    @(negedge clk);
    n_len = NW'(n); p0 = NW'(a0); p1 = NW'(a1); p2 = NW'(a2); p3 = NW'(a3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s2 = 0; s4 = 0; sp2 = 0; sp4 = 0; t2 = 0; t4 = 0; pv2 = bad; pv4 = bad; it = 0;
    while (!(s2 && s4 && sp2 && sp4) && it < 20000) begin
      if (glitch && it == 5) begin
        start = 1'b1; p0 = p0 ^ NW'(2); n_len = NW'(40);
      end else if (glitch && it == 6) begin
        start = 1'b0; p0 = NW'(a0); n_len = NW'(n);
      end
      if (vld2) begin
        lane_chk(2, n, a0, a1, a2, a3, t2, {{(2*NW){1'b0}}, addr2}, {6'd0, bank2},
                 {{(2*NW){1'b0}}, ofs2}, col2);
        t2++;
      end
      if (vld4) begin
        lane_chk(4, n, a0, a1, a2, a3, t4, addr4, bank4, ofs4, col4);
        t4++;
      end
      if (done2 && !s2) begin
        s2 = 1;
        chk(pv2, "R7", "m=2 done right after last valid cycle", 0, 1);
        chk(err2 == bad, "R2", $sformatf("m=2 n=%0d cfg_err", n), int'(err2), int'(bad));
        chk(t2 == (bad ? 0 : n / 2), "R6", $sformatf("m=2 n=%0d valid cycles", n), t2, bad ? 0 : n / 2);
        chk(int'(cnt2) == e2, "R7", $sformatf("m=2 n=%0d p0=%0d coll_count", n, a0), int'(cnt2), e2);
        chk(pass2 == (!bad && e2 == 0), "R7", "m=2 pass", int'(pass2), int'(!bad && e2 == 0));
      end
      if (done4 && !s4) begin
        s4 = 1;
        chk(pv4, "R7", "m=4 done right after last valid cycle", 0, 1);
        chk(err4 == bad, "R2", $sformatf("m=4 n=%0d cfg_err", n), int'(err4), int'(bad));
        chk(t4 == (bad ? 0 : n / 4), "R6", $sformatf("m=4 n=%0d valid cycles", n), t4, bad ? 0 : n / 4);
        chk(int'(cnt4) == e4, "R7", $sformatf("m=4 n=%0d p0=%0d coll_count", n, a0), int'(cnt4), e4);
        chk(pass4 == (!bad && e4 == 0), "R7", "m=4 pass", int'(pass4), int'(!bad && e4 == 0));
      end
      if (pd2 && !sp2) begin
        sp2 = 1;
        chk(pok2 == eok, "R9", $sformatf("m=2 n=%0d p=%0d,%0d,%0d,%0d prm_ok", n, a0, a1, a2, a3),
            int'(pok2), int'(eok));
      end
      if (pd4 && !sp4) begin
        sp4 = 1;
        chk(pok4 == eok, "R9", "m=4 prm_ok", int'(pok4), int'(eok));
      end
      pv2 = vld2;
      pv4 = vld4;
      @(negedge clk);
      it++;
    end
    chk(s2 && s4 && sp2 && sp4, "R7", "run completion", 0, 1);
    // results and flags held after completion
    repeat (3) @(negedge clk);
    chk(!done2 && !pd2 && int'(cnt2) == e2 && pok2 == eok, "R10",
        "m=2 results held, pulses low", int'(cnt2), e2);
    if (glitch)
      chk(n_fail == f0, "R8", "start while busy disturbed the pass", n_fail - f0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy2 && !done2 && !err2 && !pass2 && !vld2 && !col2 && cnt2 == '0 && !pd2 && !pok2,
        "R1", "m=2 reset state", 0, 0);
    chk(!busy4 && !done4 && !err4 && !pass4 && !vld4 && !col4 && cnt4 == '0 && !pd4 && !pok4,
        "R1", "m=4 reset state", 0, 0);

    // R2 rejected configurations
    run_one(22, 3, 2, 0, 2, 0);
    run_one(4, 1, 0, 0, 0, 0);
    run_one(24, 24, 2, 0, 2, 0);
    run_one(24, 5, 2, 0, 30, 0);

    // R3 R5 R9: sweep every p0 residue for N=24
    for (int a0 = 0; a0 < 24; a0++)
      for (int a1 = 0; a1 < 3; a1++)
        for (int a2 = 0; a2 < 2; a2++)
          run_one(24, a0, a1 * 2 + (a1 == 2 ? 1 : 0), a2 * 3, (a2 == 0) ? 2 : 5, 0);

    // N=40: order-2 class, equal even offsets
    for (int a0 = 1; a0 < 40; a0 += 2) begin
      run_one(40, a0, 2, 0, 2, 0);
      run_one(40, a0, 6, 4, 10, 0);
    end

    // N=32 and N=48: divisible by 8
    for (int a0 = 1; a0 < 32; a0 += 4) run_one(32, a0, 4, 0, 12, 0);
    run_one(48, 7, 10, 0, 10, 0);
    run_one(48, 13, 4, 8, 20, 0);

    // R8 start pulse in the middle of a pass
    run_one(24, 5, 2, 0, 2, 1);
    run_one(40, 9, 0, 2, 6, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule